// File: doc/BRIEF.md
# Startup Supply Source Sequencer

This block is the digital sequencer behind an on-chip high-voltage startup current source and the line-undervoltage (brownout) qualifier of an offline power controller. It takes comparator decisions that are already digital: line voltage above its minimum, above the start level and below the stop level; supply voltage above the turn-on level and below the restart, inhibit and reset levels; and a thermal shutdown flag. A slow timebase tick drives the brownout filter. It drives two current-source enables (low and high current), a brownout flag and a one-cycle "start allowed" pulse for the main switching controller.

The source state machine has four states. `SRC_OFF` is forced by thermal shutdown. In `SRC_STOP` the source is idle, either because the supply has reached the turn-on level or because the line is too low to feed the source. `SRC_LOW` is the reduced-current mode used while the supply pin is near ground, which protects against a shorted supply pin. `SRC_HIGH` is the normal charging mode. The transitions are:
- thermal entry, from any state to `SRC_OFF`;
- thermal exit, from `SRC_OFF` back into charging;
- charge done, from charging to `SRC_STOP` when the turn-on level is reached or the line drops below its minimum;
- recharge, from `SRC_STOP` to charging at the restart level;
- current-level swap, between `SRC_LOW` and `SRC_HIGH` as the supply crosses the inhibit level.

Together these hold the supply between the restart and turn-on levels while the controller waits for the line.

Brownout is declared only after the line has stayed below the stop level for a whole dropout window of `DROP_TICKS` ticks. Any return above the stop level restarts that window, so a rectified line that is not filtered can be monitored. After reset the line counts as unqualified, with the brownout flag set, until the line is seen above the start level. Switching is allowed only on the next rising crossing of the turn-on level while the line is qualified.

Top module: `hvs_startup_seq`

## Requirements
- R1: After reset, both source enables are 0, brownout is 1 and the start pulse is 0.
- R2: While thermal shutdown is asserted, both source enables are 0 from the next cycle on, whatever the state.
- R3: When the source is charging, it uses the low enable while VCC is below the inhibit level and the high enable otherwise. The two enables are never 1 together.
- R4: When VCC reaches the turn-on level, the source stops. It stays stopped until VCC is below the restart level, then resumes.
- R5: While HV is below its minimum level, the source stays off, even when VCC is below the restart level.
- R6: When thermal shutdown is released, the source resumes charging with no other event needed.
- R7: Brownout becomes 1 once HV has stayed below the stop level for `DROP_TICKS` ticks.
- R8: Each time HV is no longer below the stop level, the dropout count restarts from zero.
- R9: Brownout clears in the cycle after HV is seen above the start level.
- R10: The start output is a single-cycle pulse. It is raised on a rising edge of the VCC turn-on flag, and only if brownout was 0 and thermal shutdown was inactive.
- R11: VCC below the reset level sets brownout back to 1 and clears the dropout count and the turn-on edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase tick for the dropout window |
| hv_above_min | input | 1 | HV is above the minimum level for source operation |
| hv_above_start | input | 1 | HV is above the start level |
| hv_below_stop | input | 1 | HV is below the stop level |
| vcc_above_on | input | 1 | VCC is at or above the turn-on level |
| vcc_below_restart | input | 1 | VCC is below the restart level |
| vcc_below_inhibit | input | 1 | VCC is below the inhibit level |
| vcc_below_reset | input | 1 | VCC is below the logic reset level |
| thermal_sd | input | 1 | Thermal shutdown active |
| src_low_en | output | 1 | Enable of the low-current source |
| src_high_en | output | 1 | Enable of the high-current source |
| brownout | output | 1 | Line is not qualified |
| start_pulse | output | 1 | One-cycle permission to begin switching |

## Verification
Every output is registered once, so a change in the comparator flags shows up on the enables, the brownout flag and the start pulse one clock edge later. The single exception is the brownout set, which comes one edge after the tick that completes the window. The driver changes inputs just after a rising edge, steps one edge, and only then queues the values it expects. The monitor compares them at the following falling edge. For the dropout window, ticks are counted in the bench: the last tick is checked with brownout still 0, and the next edge with brownout at 1.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_STOP = 2'd1,
        SRC_LOW  = 2'd2,
        SRC_HIGH = 2'd3
    } src_state_t;
endpackage

// File: rtl/hvs_source_fsm.sv
module hvs_source_fsm
    import hvs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thermal_sd,
    input  logic hv_above_min,
    input  logic vcc_above_on,
    input  logic vcc_below_restart,
    input  logic vcc_below_inhibit,
    output logic src_low_en,
    output logic src_high_en
);
    src_state_t state_q, state_d, charge_lvl;

    // charging current level picked from the inhibit comparator
    assign charge_lvl = vcc_below_inhibit ? SRC_LOW : SRC_HIGH;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OFF:  state_d = (hv_above_min && !vcc_above_on) ? charge_lvl : SRC_STOP;
            SRC_STOP: state_d = (vcc_below_restart && hv_above_min) ? charge_lvl : SRC_STOP;
            SRC_LOW,
            SRC_HIGH: state_d = (vcc_above_on || !hv_above_min) ? SRC_STOP : charge_lvl;
            default:  state_d = SRC_STOP;
        endcase
        if (thermal_sd) state_d = SRC_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        src_low_en  = (state_q == SRC_LOW);
        src_high_en = (state_q == SRC_HIGH);
    end
endmodule

// File: rtl/hvs_dropout_filter.sv
module hvs_dropout_filter #(
    parameter int DROP_TICKS = 68
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hv_below_stop,
    input  logic hv_above_start,
    input  logic vcc_below_reset,
    output logic brownout
);
    localparam int CW = $clog2(DROP_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DROP_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (vcc_below_reset || !hv_below_stop) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               brownout <= 1'b1;
        else if (vcc_below_reset) brownout <= 1'b1;
        else if (hv_above_start)  brownout <= 1'b0;
        else if (cnt_q == LIMIT)  brownout <= 1'b1;
    end
endmodule

// File: rtl/hvs_start_gate.sv
module hvs_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_on,
    input  logic brownout,
    input  logic thermal_sd,
    input  logic vcc_below_reset,
    output logic start_pulse
);
    logic on_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_prev_q   <= 1'b0;
            start_pulse <= 1'b0;
        end else if (vcc_below_reset) begin
            on_prev_q   <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            on_prev_q   <= vcc_above_on;
            start_pulse <= vcc_above_on && !on_prev_q && !brownout && !thermal_sd;
        end
    end
endmodule

// File: rtl/hvs_startup_seq.sv
module hvs_startup_seq #(
    parameter int DROP_TICKS = 68
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hv_above_min,
    input  logic hv_above_start,
    input  logic hv_below_stop,
    input  logic vcc_above_on,
    input  logic vcc_below_restart,
    input  logic vcc_below_inhibit,
    input  logic vcc_below_reset,
    input  logic thermal_sd,
    output logic src_low_en,
    output logic src_high_en,
    output logic brownout,
    output logic start_pulse
);
    hvs_source_fsm src_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .thermal_sd        (thermal_sd),
        .hv_above_min      (hv_above_min),
        .vcc_above_on      (vcc_above_on),
        .vcc_below_restart (vcc_below_restart),
        .vcc_below_inhibit (vcc_below_inhibit),
        .src_low_en        (src_low_en),
        .src_high_en       (src_high_en)
    );

    hvs_dropout_filter #(.DROP_TICKS(DROP_TICKS)) drop_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .hv_below_stop   (hv_below_stop),
        .hv_above_start  (hv_above_start),
        .vcc_below_reset (vcc_below_reset),
        .brownout        (brownout)
    );

    hvs_start_gate gate_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .vcc_above_on    (vcc_above_on),
        .brownout        (brownout),
        .thermal_sd      (thermal_sd),
        .vcc_below_reset (vcc_below_reset),
        .start_pulse     (start_pulse)
    );
endmodule

// File: rtl/hvs_startup_seq_chk.sv
module hvs_startup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic hv_above_min,
    input logic hv_above_start,
    input logic hv_below_stop,
    input logic vcc_above_on,
    input logic vcc_below_restart,
    input logic vcc_below_inhibit,
    input logic vcc_below_reset,
    input logic thermal_sd,
    input logic src_low_en,
    input logic src_high_en,
    input logic brownout,
    input logic start_pulse
);
    assert_enables_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_low_en && src_high_en));

    assert_thermal_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_sd |=> (!src_low_en && !src_high_en));

    assert_stop_at_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_above_on |=> (!src_low_en && !src_high_en));

    assert_hv_min_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_above_min |=> (!src_low_en && !src_high_en));

    assert_brownout_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_above_start && !vcc_below_reset) |=> !brownout);

    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_start_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> (!$past(brownout) && !$past(thermal_sd)));

    assert_vcc_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_reset |=> (brownout && !start_pulse));
endmodule

bind hvs_startup_seq hvs_startup_seq_chk chk_i (.*);

// File: tb/hvs_startup_seq_tb_top.sv
`timescale 1ns/1ps
module hvs_startup_seq_tb_top;
    localparam int DROP = 8;

    logic clk = 1'b0;
    logic rst_n, tick, hv_min, hv_start, hv_stop, v_on, v_restart, v_inhibit, v_reset, tsd;
    logic lo, hi, bo, st;

    always #2 clk = ~clk;

    hvs_startup_seq #(.DROP_TICKS(DROP)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hv_above_min(hv_min), .hv_above_start(hv_start), .hv_below_stop(hv_stop),
        .vcc_above_on(v_on), .vcc_below_restart(v_restart),
        .vcc_below_inhibit(v_inhibit), .vcc_below_reset(v_reset),
        .thermal_sd(tsd),
        .src_low_en(lo), .src_high_en(hi), .brownout(bo), .start_pulse(st)
    );

    typedef struct {
        string req;
        logic  lo, hi, bo, st;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic e_lo, e_hi, e_bo, e_st;

    // monitor: compare every queued expectation away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if ({lo, hi, bo, st} !== {it.lo, it.hi, it.bo, it.st}) begin
                errors++;
                $display("FAIL %s: got lo/hi/bo/st=%b%b%b%b expected %b%b%b%b",
                         it.req, lo, hi, bo, st, it.lo, it.hi, it.bo, it.st);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string r);
        exp_t it;
        it.req = r; it.lo = e_lo; it.hi = e_hi; it.bo = e_bo; it.st = e_st;
        q.push_back(it);
    endtask

    task automatic tick_once();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tick = 0; hv_min = 0; hv_start = 0; hv_stop = 0; v_on = 0;
        v_restart = 1; v_inhibit = 1; v_reset = 1; tsd = 0;
        e_lo = 0; e_hi = 0; e_bo = 1; e_st = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        expect_now("R1");
        step(); expect_now("R5");                          // line too low: stays off
        hv_min = 1; step(); e_lo = 1; expect_now("R3");    // low current near ground
        v_reset = 0; v_inhibit = 0; step();
        e_lo = 0; e_hi = 1; expect_now("R3");              // high current
        v_restart = 0; step(); expect_now("R4");           // still charging
        v_on = 1; step(); e_hi = 0; expect_now("R4");      // stop at turn-on
        expect_now("R10");                                 // no start while brownout
        v_on = 0; step(); expect_now("R4");                // hysteresis: stays off
        v_restart = 1; step(); e_hi = 1; expect_now("R4"); // recharge
        hv_min = 0; step(); e_hi = 0; expect_now("R5");
        step(); expect_now("R5");
        hv_min = 1; step(); e_hi = 1; expect_now("R3");
        tsd = 1; step(); e_hi = 0; expect_now("R2");
        step(); expect_now("R2");
        tsd = 0; step(); e_hi = 1; expect_now("R6");
        hv_start = 1; step(); e_bo = 0; expect_now("R9");
        hv_start = 0;
        v_restart = 0; v_on = 1; step();
        e_hi = 0; e_st = 1; expect_now("R10");
        step(); e_st = 0; expect_now("R10");
        v_on = 0;
        hv_stop = 1; step();
        for (int i = 0; i < DROP - 1; i++) tick_once();
        step(); expect_now("R7");                          // window not yet full
        hv_stop = 0; step();                               // retrigger
        hv_stop = 1;
        for (int i = 0; i < DROP - 1; i++) tick_once();
        step(); expect_now("R8");
        tick_once(); expect_now("R7");                     // count full, flag next edge
        step(); e_bo = 1; expect_now("R7");
        v_on = 1; step(); expect_now("R10");               // blocked by brownout
        v_on = 0; hv_stop = 0;
        hv_start = 1; step(); e_bo = 0; expect_now("R9");
        hv_start = 0;
        v_reset = 1; v_restart = 1; v_inhibit = 1; step();
        e_lo = 1; e_bo = 1; expect_now("R11");
        @(negedge clk); #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule